// File: doc/BRIEF.md
# Banked Index-Data Configuration Register File

This block holds the configuration space of a multi-function I/O controller. Software reaches it through two adjacent byte-wide I/O ports. The lower port is a pointer register. The upper port is a window that reads or writes whichever configuration byte the pointer selects. The window has no storage of its own.

Pointer values below 30h reach a small set of shared registers. These are the device-number selector at 07h and sixteen controller-wide bytes at 20h–2Fh. Pointer values from 30h upward reach one of eight per-function banks, and the device-number selector chooses which bank. A 2-bit strap input places the port pair at one of two base addresses, or it switches decoding off entirely.

Every stored byte is exported to the downstream functions. In addition, bit 0 of each bank's control byte drives a per-function enable output.

Top module: `cfg_space_top`

## Requirements
- R1: With strap = 2'b10 the pointer port decodes at 002Eh and the window port at 002Fh; a read of any other address leaves io_rdata_oe low.
- R2: With strap = 2'b11 the pointer port decodes at 015Ch and the window port at 015Dh, and 002Eh/002Fh are not decoded.
- R3: With strap = 2'b00 or 2'b01 neither port decodes: io_rdata_oe stays low on every read, and writes to any address change no stored byte and no output.
- R4: The pointer is an 8-bit read/write register that resets to 00h; a read of the pointer port returns the value last written to it.
- R5: A window access with pointer 07h reaches the device-number register. Pointers 20h–2Fh reach sixteen shared bytes, exported on glob_regs with byte 20h+n at bits [8n+7:8n].
- R6: A window access with pointer 30h or higher reaches the byte at that pointer in the bank chosen by the device number. Writes to one bank leave every other bank unchanged.
- R7: Device numbers 00h–03h select banks 0–3 and 05h–08h select banks 4–7. With any other device number, banked window reads return FFh and banked writes are ignored.
- R8: Each bank implements these pointers, in this slot order: 30h, 60h–63h, 70h–71h, 74h–75h and F0h–FEh (24 slots). Bank b slot s is exported on bank_regs at bits [(24b+s)*8 +: 8]. A window read of an unimplemented pointer returns FFh, and a write to one is ignored.
- R9: A write strobe is captured at the rising clock edge, and a read in the following cycle returns the new value. Read data is combinational from the current state.
- R10: dev_en[b] equals bit 0 of bank b's 30h byte.
- R11: Reset (rst_n low, asynchronous) clears the pointer, the device number, all shared bytes and all banked bytes to 00h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| strap | input | 2 | Base-address / disable strap |
| io_addr | input | 16 | I/O address |
| io_rd | input | 1 | Read strobe |
| io_wr | input | 1 | Write strobe |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Read data (00h when not driven) |
| io_rdata_oe | output | 1 | High when a decoded read drives io_rdata |
| dev_en | output | 8 | Per-bank enable (bit 0 of each 30h byte) |
| glob_regs | output | 128 | Shared bytes 20h–2Fh |
| bank_regs | output | 1536 | All banked bytes, bank-major, slot order of R8 |

## Verification
A corrupted pointer or device number would show up on the next window read: the returned byte would come from the wrong slot or the wrong bank, or it would be FFh where a real byte was expected. The bench therefore reads back every byte it writes, reading the next cycle it can. A stray write into a neighbouring bank or slot appears at once on bank_regs and dev_en. The bench compares those exports after each phase, including after writes made with decoding disabled or through an unassigned device number. Any mistake in strap decoding shows on io_rdata_oe in the same cycle as the read strobe.

// File: rtl/cfg_pkg.sv
package cfg_pkg;

    localparam int NBANK  = 8;
    localparam int NSLOT  = 24;
    localparam int NGLOB  = 16;
    localparam int BANK_W = $clog2(NBANK);
    localparam int SLOT_W = $clog2(NSLOT);
    localparam int GLOB_W = $clog2(NGLOB);

    localparam logic [7:0] LDN_PTR    = 8'h07;
    localparam logic [3:0] GLOB_HI    = 4'h2;
    localparam logic [7:0] BANK_SPLIT = 8'h30;
    localparam logic [7:0] NO_DATA    = 8'hFF;

    typedef enum logic [1:0] {
        TGT_NONE,
        TGT_LDN,
        TGT_GLOB,
        TGT_BANK
    } tgt_e;

    typedef struct packed {
        logic              ok;
        logic [SLOT_W-1:0] num;
    } slot_t;

    typedef struct packed {
        logic              ok;
        logic [BANK_W-1:0] num;
    } bank_t;

    // Pointer to slot: 30h, 60h-63h, 70h-71h, 74h-75h, F0h-FEh.
    function automatic slot_t slot_of(input logic [7:0] ptr);
        slot_t r;
        r.ok  = 1'b1;
        r.num = '0;
        if (ptr == BANK_SPLIT)
            r.num = '0;
        else if (ptr[7:2] == 6'b0110_00)
            r.num = SLOT_W'(1 + ptr[1:0]);
        else if (ptr[7:1] == 7'b0111_000)
            r.num = SLOT_W'(5 + ptr[0]);
        else if (ptr[7:1] == 7'b0111_010)
            r.num = SLOT_W'(7 + ptr[0]);
        else if (ptr[7:4] == 4'hF && ptr[3:0] != 4'hF)
            r.num = SLOT_W'(9 + ptr[3:0]);
        else
            r.ok = 1'b0;
        return r;
    endfunction

    // Device number to bank: 00h-03h -> 0-3, 05h-08h -> 4-7.
    function automatic bank_t bank_of(input logic [7:0] dn);
        bank_t r;
        r.ok  = 1'b1;
        r.num = '0;
        if (dn <= 8'h03)
            r.num = BANK_W'(dn);
        else if (dn >= 8'h05 && dn <= 8'h08)
            r.num = BANK_W'(dn - 8'h01);
        else
            r.ok = 1'b0;
        return r;
    endfunction

endpackage

// File: rtl/cfg_port_decode.sv
module cfg_port_decode #(
    parameter int              AW     = 16,
    parameter logic [AW-1:0]   BASE_A = 16'h002E,
    parameter logic [AW-1:0]   BASE_B = 16'h015C
) (
    input  logic [1:0]    strap,
    input  logic [AW-1:0] addr,
    input  logic          rd,
    input  logic          wr,
    output logic          ptr_rd,
    output logic          ptr_wr,
    output logic          win_rd,
    output logic          win_wr
);
    logic          enabled;
    logic [AW-1:0] base;
    logic          hit_ptr;
    logic          hit_win;

    always_comb begin
        enabled = strap[1];
        base    = strap[0] ? BASE_B : BASE_A;
        hit_ptr = enabled && (addr == base);
        hit_win = enabled && (addr == base + AW'(1));
        ptr_rd  = hit_ptr && rd;
        ptr_wr  = hit_ptr && wr;
        win_rd  = hit_win && rd;
        win_wr  = hit_win && wr;
    end
endmodule

// File: rtl/cfg_target_map.sv
module cfg_target_map
    import cfg_pkg::*;
(
    input  logic [7:0]        ptr,
    input  logic [7:0]        dev_num,
    output tgt_e              tgt,
    output logic [GLOB_W-1:0] glob_num,
    output logic [BANK_W-1:0] bank_num,
    output logic [SLOT_W-1:0] slot_num
);
    slot_t s;
    bank_t b;

    always_comb begin
        s        = slot_of(ptr);
        b        = bank_of(dev_num);
        glob_num = ptr[GLOB_W-1:0];
        bank_num = b.num;
        slot_num = s.num;
        tgt      = TGT_NONE;
        if (ptr < BANK_SPLIT) begin
            if (ptr == LDN_PTR)
                tgt = TGT_LDN;
            else if (ptr[7:4] == GLOB_HI)
                tgt = TGT_GLOB;
        end else if (s.ok && b.ok) begin
            tgt = TGT_BANK;
        end
    end
endmodule

// File: rtl/cfg_regfile.sv
module cfg_regfile
    import cfg_pkg::*;
#(
    parameter int NB  = NBANK,
    parameter int NS  = NSLOT,
    parameter int NG  = NGLOB,
    localparam int BW = $clog2(NB),
    localparam int SW = $clog2(NS),
    localparam int GW = $clog2(NG)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      ptr_wr,
    input  logic                      win_wr,
    input  logic [7:0]                wdata,
    input  tgt_e                      tgt,
    input  logic [GW-1:0]             glob_num,
    input  logic [BW-1:0]             bank_num,
    input  logic [SW-1:0]             slot_num,
    output logic [7:0]                ptr_q,
    output logic [7:0]                dev_num_q,
    output logic [NG-1:0][7:0]        glob_q,
    output logic [NB-1:0][NS-1:0][7:0] bank_q
);
    typedef struct packed {
        logic [7:0]                 ptr;
        logic [7:0]                 dev_num;
        logic [NG-1:0][7:0]         glob;
        logic [NB-1:0][NS-1:0][7:0] bank;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (ptr_wr)
            st_d.ptr = wdata;
        if (win_wr) begin
            case (tgt)
                TGT_LDN:  st_d.dev_num = wdata;
                TGT_GLOB: st_d.glob[glob_num] = wdata;
                TGT_BANK: st_d.bank[bank_num][slot_num] = wdata;
                default:  ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign ptr_q     = st_q.ptr;
    assign dev_num_q = st_q.dev_num;
    assign glob_q    = st_q.glob;
    assign bank_q    = st_q.bank;
endmodule

// File: rtl/cfg_space_top.sv
module cfg_space_top
    import cfg_pkg::*;
#(
    parameter int AW = 16,
    localparam int GBITS = NGLOB * 8,
    localparam int BBITS = NBANK * NSLOT * 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       strap,
    input  logic [AW-1:0]    io_addr,
    input  logic             io_rd,
    input  logic             io_wr,
    input  logic [7:0]       io_wdata,
    output logic [7:0]       io_rdata,
    output logic             io_rdata_oe,
    output logic [NBANK-1:0] dev_en,
    output logic [GBITS-1:0] glob_regs,
    output logic [BBITS-1:0] bank_regs
);
    logic ptr_rd, ptr_wr, win_rd, win_wr;
    tgt_e tgt;
    logic [GLOB_W-1:0] glob_num;
    logic [BANK_W-1:0] bank_num;
    logic [SLOT_W-1:0] slot_num;
    logic [7:0] ptr_q, dev_num_q;
    logic [NGLOB-1:0][7:0] glob_q;
    logic [NBANK-1:0][NSLOT-1:0][7:0] bank_q;

    cfg_port_decode #(.AW(AW)) u_dec (
        .strap  (strap),
        .addr   (io_addr),
        .rd     (io_rd),
        .wr     (io_wr),
        .ptr_rd (ptr_rd),
        .ptr_wr (ptr_wr),
        .win_rd (win_rd),
        .win_wr (win_wr)
    );

    cfg_target_map u_map (
        .ptr      (ptr_q),
        .dev_num  (dev_num_q),
        .tgt      (tgt),
        .glob_num (glob_num),
        .bank_num (bank_num),
        .slot_num (slot_num)
    );

    cfg_regfile u_rf (
        .clk       (clk),
        .rst_n     (rst_n),
        .ptr_wr    (ptr_wr),
        .win_wr    (win_wr),
        .wdata     (io_wdata),
        .tgt       (tgt),
        .glob_num  (glob_num),
        .bank_num  (bank_num),
        .slot_num  (slot_num),
        .ptr_q     (ptr_q),
        .dev_num_q (dev_num_q),
        .glob_q    (glob_q),
        .bank_q    (bank_q)
    );

    // Read path: pointer readback or window into the selected byte.
    always_comb begin
        io_rdata_oe = ptr_rd || win_rd;
        io_rdata    = 8'h00;
        if (ptr_rd) begin
            io_rdata = ptr_q;
        end else if (win_rd) begin
            case (tgt)
                TGT_LDN:  io_rdata = dev_num_q;
                TGT_GLOB: io_rdata = glob_q[glob_num];
                TGT_BANK: io_rdata = bank_q[bank_num][slot_num];
                default:  io_rdata = NO_DATA;
            endcase
        end
    end

    for (genvar b = 0; b < NBANK; b++) begin : g_en
        assign dev_en[b] = bank_q[b][0][0];
    end

    assign glob_regs = glob_q;
    assign bank_regs = bank_q;
endmodule

// File: rtl/cfg_space_chk.sv
module cfg_space_chk
    import cfg_pkg::*;
#(
    parameter int NB = NBANK
) (
    input logic          clk,
    input logic          rst_n,
    input logic [1:0]    strap,
    input logic          io_rd,
    input logic          io_wr,
    input logic [7:0]    io_rdata,
    input logic          io_rdata_oe,
    input logic [NB-1:0] dev_en,
    input logic [7:0]    ptr_q,
    input logic [7:0]    dev_num_q,
    input tgt_e          tgt,
    input logic          win_rd
);
    logic quiet;
    assign quiet = !io_wr || !strap[1];

    p_silent_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !strap[1] |-> !io_rdata_oe);

    p_drive_on_read_r1: assert property (@(posedge clk) disable iff (!rst_n)
        io_rdata_oe |-> io_rd);

    p_ptr_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        quiet |=> $stable(ptr_q));

    p_devnum_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        quiet |=> $stable(dev_num_q));

    p_enable_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        quiet |=> $stable(dev_en));

    p_unmapped_ff_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (win_rd && tgt == TGT_NONE) |-> (io_rdata_oe && io_rdata == NO_DATA));
endmodule

bind cfg_space_top cfg_space_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .strap       (strap),
    .io_rd       (io_rd),
    .io_wr       (io_wr),
    .io_rdata    (io_rdata),
    .io_rdata_oe (io_rdata_oe),
    .dev_en      (dev_en),
    .ptr_q       (ptr_q),
    .dev_num_q   (dev_num_q),
    .tgt         (tgt),
    .win_rd      (win_rd)
);

// File: tb/tb_cfg_space_top.sv
module tb_cfg_space_top;
    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [1:0]    strap = 2'b10;
    logic [15:0]   io_addr = '0;
    logic          io_rd = 1'b0;
    logic          io_wr = 1'b0;
    logic [7:0]    io_wdata = '0;
    logic [7:0]    io_rdata;
    logic          io_rdata_oe;
    logic [7:0]    dev_en;
    logic [127:0]  glob_regs;
    logic [1535:0] bank_regs;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    cfg_space_top dut (
        .clk(clk), .rst_n(rst_n), .strap(strap), .io_addr(io_addr),
        .io_rd(io_rd), .io_wr(io_wr), .io_wdata(io_wdata),
        .io_rdata(io_rdata), .io_rdata_oe(io_rdata_oe), .dev_en(dev_en),
        .glob_regs(glob_regs), .bank_regs(bank_regs)
    );

    // {op (1 = read-and-compare), req, addr, data/expected}
    localparam int NV = 36;
    localparam logic [28:0] VEC [NV] = '{
        {1'b0, 4'd4,  16'h002E, 8'h07},
        {1'b0, 4'd5,  16'h002F, 8'h03},
        {1'b1, 4'd5,  16'h002F, 8'h03},  // R5 device number readback
        {1'b0, 4'd6,  16'h002E, 8'h30},
        {1'b0, 4'd6,  16'h002F, 8'h01},
        {1'b1, 4'd9,  16'h002F, 8'h01},  // R9 bank 3 control
        {1'b0, 4'd6,  16'h002E, 8'h07},
        {1'b0, 4'd6,  16'h002F, 8'h00},
        {1'b0, 4'd6,  16'h002E, 8'h30},
        {1'b1, 4'd6,  16'h002F, 8'h00},  // R6 bank 0 untouched
        {1'b0, 4'd6,  16'h002F, 8'hA5},
        {1'b1, 4'd9,  16'h002F, 8'hA5},
        {1'b0, 4'd5,  16'h002E, 8'h20},
        {1'b0, 4'd5,  16'h002F, 8'h5A},
        {1'b1, 4'd5,  16'h002F, 8'h5A},  // R5 shared 20h
        {1'b0, 4'd5,  16'h002E, 8'h2F},
        {1'b0, 4'd5,  16'h002F, 8'hC3},
        {1'b1, 4'd5,  16'h002F, 8'hC3},  // R5 shared 2Fh
        {1'b1, 4'd4,  16'h002E, 8'h2F},  // R4 pointer readback
        {1'b0, 4'd8,  16'h002E, 8'h61},
        {1'b0, 4'd8,  16'h002F, 8'h11},
        {1'b1, 4'd8,  16'h002F, 8'h11},  // R8 slot 61h
        {1'b0, 4'd8,  16'h002E, 8'hFE},
        {1'b0, 4'd8,  16'h002F, 8'h77},
        {1'b1, 4'd8,  16'h002F, 8'h77},  // R8 slot FEh
        {1'b0, 4'd8,  16'h002E, 8'hFF},
        {1'b0, 4'd8,  16'h002F, 8'h12},
        {1'b1, 4'd8,  16'h002F, 8'hFF},  // R8 FFh unimplemented
        {1'b0, 4'd8,  16'h002E, 8'h64},
        {1'b1, 4'd8,  16'h002F, 8'hFF},  // R8 gap 64h
        {1'b0, 4'd8,  16'h002E, 8'h10},
        {1'b1, 4'd8,  16'h002F, 8'hFF},  // R8 shared gap 10h
        {1'b0, 4'd6,  16'h002E, 8'h07},
        {1'b0, 4'd6,  16'h002F, 8'h03},
        {1'b0, 4'd6,  16'h002E, 8'h61},
        {1'b1, 4'd6,  16'h002F, 8'h00}   // R6 bank 3 slot 61h untouched
    };

    task automatic io_write(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        io_addr = a; io_wdata = d; io_wr = 1'b1;
        @(posedge clk);
        #1 io_wr = 1'b0;
    endtask

    task automatic io_read(input logic [15:0] a, output logic [7:0] d, output logic oe);
        @(negedge clk);
        io_addr = a; io_rd = 1'b1;
        #5;
        d = io_rdata; oe = io_rdata_oe;
        @(posedge clk);
        #1 io_rd = 1'b0;
    endtask

    task automatic check(input string req, input logic [1535:0] act, input logic [1535:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic rd_chk(input string req, input logic [15:0] a,
                          input logic exp_oe, input logic [7:0] exp_d);
        logic [7:0] d;
        logic oe;
        io_read(a, d, oe);
        check({req, " oe"}, 1536'(oe), 1536'(exp_oe));
        if (exp_oe) check(req, 1536'(d), 1536'(exp_d));
    endtask

    initial begin
        logic [7:0] d;
        logic oe;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R11 / R4 reset state
        rd_chk("R4 reset pointer", 16'h002E, 1'b1, 8'h00);
        check("R11 dev_en reset", 1536'(dev_en), 1536'(0));
        check("R11 glob reset", 1536'(glob_regs), 1536'(0));
        check("R11 bank reset", bank_regs, '0);

        for (int i = 0; i < NV; i++) begin
            if (VEC[i][28]) begin
                io_read(VEC[i][23:8], d, oe);
                check($sformatf("R%0d vec%0d oe", VEC[i][27:24], i), 1536'(oe), 1536'(1));
                check($sformatf("R%0d vec%0d", VEC[i][27:24], i), 1536'(d), 1536'(VEC[i][7:0]));
            end else begin
                io_write(VEC[i][23:8], VEC[i][7:0]);
            end
        end

        check("R10 dev_en", 1536'(dev_en), 1536'(8'b0000_1001));
        check("R5 glob 20h", 1536'(glob_regs[7:0]), 1536'(8'h5A));
        check("R5 glob 2Fh", 1536'(glob_regs[127:120]), 1536'(8'hC3));
        check("R8 bank0 slot23", 1536'(bank_regs[23*8 +: 8]), 1536'(8'h77));
        check("R8 bank0 slot2", 1536'(bank_regs[2*8 +: 8]), 1536'(8'h11));
        rd_chk("R1 undecoded 0030h", 16'h0030, 1'b0, 8'h00);

        // R7 unassigned device number 04h
        io_write(16'h002E, 8'h07); io_write(16'h002F, 8'h04);
        io_write(16'h002E, 8'h30); io_write(16'h002F, 8'h55);
        rd_chk("R7 dn 04h read", 16'h002F, 1'b1, 8'hFF);
        io_write(16'h002E, 8'h07); io_write(16'h002F, 8'h05);
        io_write(16'h002E, 8'h30);
        rd_chk("R7 dn 05h bank4 clean", 16'h002F, 1'b1, 8'h00);
        io_write(16'h002E, 8'h07); io_write(16'h002F, 8'h08);
        io_write(16'h002E, 8'h30); io_write(16'h002F, 8'h01);
        check("R7 dn 08h -> bank7 enable", 1536'(dev_en), 1536'(8'b1000_1001));

        // R2 alternate base
        strap = 2'b11;
        rd_chk("R2 pointer at 015Ch", 16'h015C, 1'b1, 8'h30);
        rd_chk("R2 002Eh undecoded", 16'h002E, 1'b0, 8'h00);
        io_write(16'h015C, 8'h20);
        rd_chk("R2 window at 015Dh", 16'h015D, 1'b1, 8'h5A);

        // R3 disabled modes
        strap = 2'b01;
        rd_chk("R3 strap01 015Ch", 16'h015C, 1'b0, 8'h00);
        io_write(16'h015C, 8'h07); io_write(16'h002E, 8'h07);
        io_write(16'h002F, 8'h99); io_write(16'h015D, 8'h99);
        strap = 2'b00;
        rd_chk("R3 strap00 002Eh", 16'h002E, 1'b0, 8'h00);
        io_write(16'h015D, 8'h98); io_write(16'h002F, 8'h98);
        strap = 2'b11;
        rd_chk("R3 pointer kept", 16'h015C, 1'b1, 8'h20);
        rd_chk("R3 shared kept", 16'h015D, 1'b1, 8'h5A);
        check("R3 dev_en kept", 1536'(dev_en), 1536'(8'b1000_1001));

        // R11 reset clears everything
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        strap = 2'b10;
        rd_chk("R11 pointer after reset", 16'h002E, 1'b1, 8'h00);
        check("R11 dev_en after reset", 1536'(dev_en), 1536'(0));
        check("R11 glob after reset", 1536'(glob_regs), 1536'(0));
        check("R11 bank after reset", bank_regs, '0);
        io_write(16'h002E, 8'h07);
        rd_chk("R11 device number after reset", 16'h002F, 1'b1, 8'h00);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule